// File: doc/BRIEF.md
# Memory-Side Atomic and Masked-Write Unit

This block is a memory target that serves one single-beat request at a time from a small word-addressed RAM held inside it. A request carries a command, a word address, a per-byte enable mask, an operation code and a data operand. The unit reads words, writes them under a byte mask, and runs read-modify-write operations (add, AND, OR, XOR, swap) at the memory end. The requester sends only the operand, never a separate read.

Atomic requests return the word as it was before the update. The modify-write variant makes the same update and returns nothing. Writes are store-and-forget and never produce a reply. A write whose mask is not all ones is merged inside the unit with one internal read and one write. The external interface carries no extra traffic for it.

Top module: `mematom_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A write (`req_cmd` = 1) with every mask bit set completes in the accepting cycle. `req_ready` stays 1 on the next cycle and no reply beat appears.
- R3: A write whose mask is not all ones updates only the bytes whose mask bit is set, where mask bit i covers data bits 8i+7..8i. It holds `req_ready` low for exactly the one cycle after acceptance and gives no reply beat. A zero mask leaves the word unchanged.
- R4: A read (`req_cmd` = 0) gives exactly one `rsp_valid` beat, in the cycle after acceptance, carrying the stored word.
- R5: An atomic request (`req_cmd` = 2) gives one reply beat in the cycle after acceptance. The beat carries the complete word as it was before the update. The updated word is written back.
- R6: The operation code selects the new value from old word W and operand D: 0 gives W+D modulo 2^DATA_W, 1 gives W AND D, 2 gives W OR D, 3 gives W XOR D, 4 gives D. Codes 5 to 7 leave the word unchanged.
- R7: For atomic and modify-write requests, only the bytes enabled by the mask take the operation result. Disabled bytes keep their old value.
- R8: A modify-write request (`req_cmd` = 3) stores the same result an atomic request would store and produces no reply beat.
- R9: Every request other than a full-mask write keeps `req_ready` low for exactly one cycle after acceptance. A reply beat never lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_cmd | input | 2 | 0 read, 1 write, 2 atomic, 3 modify-write |
| req_addr | input | ADDR_W | Word address |
| req_mask | input | DATA_W/8 | Byte enables |
| req_op | input | 3 | Operation code for atomic and modify-write |
| req_data | input | DATA_W | Write data or operand |
| rsp_valid | output | 1 | Reply beat present |
| rsp_data | output | DATA_W | Reply word |

## Verification
The bench sweeps all eight operation codes against full, zero and sparse masks, for both the atomic and the silent command. Each result is read back to separate what was returned from what was stored. A unit that returned the merged word instead of the full old word, or that let disabled bytes take the result, fails these comparisons. Add overflow at the top of the word shows whether a carry wrongly stops at a byte boundary. Reserved codes and the zero mask show whether a word is disturbed when it must not be. A reply beat after a write or modify-write, a missing or doubled beat after a read, and a full-mask write that stalls the port are all caught by cycle-exact sampling of `req_ready` and `rsp_valid`.

// File: rtl/mematom_pkg.sv
package mematom_pkg;
   localparam logic [1:0] CMD_READ   = 2'd0;
   localparam logic [1:0] CMD_WRITE  = 2'd1;
   localparam logic [1:0] CMD_ATOMIC = 2'd2;
   localparam logic [1:0] CMD_MODWR  = 2'd3;

   localparam logic [2:0] OP_ADD  = 3'd0;
   localparam logic [2:0] OP_AND  = 3'd1;
   localparam logic [2:0] OP_OR   = 3'd2;
   localparam logic [2:0] OP_XOR  = 3'd3;
   localparam logic [2:0] OP_SWAP = 3'd4;

   typedef enum logic {ST_IDLE, ST_MERGE} state_e;
endpackage

// File: rtl/mematom_alu.sv
module mematom_alu
   import mematom_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] result
);
   always_comb begin
      unique case (op)
         OP_ADD:  result = old_word + operand;
         OP_AND:  result = old_word & operand;
         OP_OR:   result = old_word | operand;
         OP_XOR:  result = old_word ^ operand;
         OP_SWAP: result = operand;
         default: result = old_word;
      endcase
   end
endmodule

// File: rtl/mematom_merge.sv
module mematom_merge #(
   parameter int DATA_W = 64,
   localparam int LANES = DATA_W / 8
) (
   input  logic [LANES-1:0]  lane_en,
   input  logic [DATA_W-1:0] keep_word,
   input  logic [DATA_W-1:0] new_word,
   output logic [DATA_W-1:0] merged
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[8*i +: 8] = lane_en[i] ? new_word[8*i +: 8] : keep_word[8*i +: 8];
   end
endmodule

// File: rtl/mematom_ram.sv
module mematom_ram #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 4,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
      if (rd_en) rd_data <= store[rd_addr];
   end
endmodule

// File: rtl/mematom_unit.sv
module mematom_unit
   import mematom_pkg::*;
#(
   parameter int DATA_W          = 64,
   parameter int ADDR_W          = 4,
   parameter bit FAST_FULL_WRITE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [1:0]            req_cmd,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W/8-1:0]   req_mask,
   input  logic [2:0]            req_op,
   input  logic [DATA_W-1:0]     req_data,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_data
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_width
      $error("mematom_unit: DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("mematom_unit: ADDR_W must lie in 1..12");
   end

   state_e             state_q;
   logic [1:0]         cmd_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [LANES-1:0]   mask_q;
   logic [2:0]         op_q;
   logic [DATA_W-1:0]  data_q;

   logic               accept, fast_wr, in_merge;
   logic [DATA_W-1:0]  old_word, alu_out, new_src, merged;
   logic               ram_we;
   logic [ADDR_W-1:0]  ram_waddr;
   logic [DATA_W-1:0]  ram_wdata;

   assign in_merge  = (state_q == ST_MERGE);
   assign req_ready = !in_merge;
   assign accept    = req_valid && req_ready;

   if (FAST_FULL_WRITE) begin : g_fast
      assign fast_wr = (req_cmd == CMD_WRITE) && (&req_mask);
   end else begin : g_slow
      assign fast_wr = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else if (in_merge) begin
         state_q <= ST_IDLE;
      end else if (accept && !fast_wr) begin
         state_q <= ST_MERGE;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         cmd_q  <= req_cmd;
         addr_q <= req_addr;
         mask_q <= req_mask;
         op_q   <= req_op;
         data_q <= req_data;
      end
   end

   mematom_alu #(.DATA_W(DATA_W)) u_alu (
      .op       (op_q),
      .old_word (old_word),
      .operand  (data_q),
      .result   (alu_out)
   );

   assign new_src = (cmd_q == CMD_WRITE) ? data_q : alu_out;

   mematom_merge #(.DATA_W(DATA_W)) u_merge (
      .lane_en   (mask_q),
      .keep_word (old_word),
      .new_word  (new_src),
      .merged    (merged)
   );

   assign ram_we    = (accept && fast_wr) || (in_merge && cmd_q != CMD_READ);
   assign ram_waddr = in_merge ? addr_q : req_addr;
   assign ram_wdata = in_merge ? merged : req_data;

   mematom_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk     (clk),
      .rd_en   (accept && !fast_wr),
      .rd_addr (req_addr),
      .rd_data (old_word),
      .wr_en   (ram_we),
      .wr_addr (ram_waddr),
      .wr_data (ram_wdata)
   );

   assign rsp_valid = in_merge && (cmd_q == CMD_READ || cmd_q == CMD_ATOMIC);
   assign rsp_data  = old_word;
endmodule

// File: rtl/mematom_chk.sv
module mematom_chk
   import mematom_pkg::*;
#(
   parameter int LANES           = 8,
   parameter bit FAST_FULL_WRITE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [1:0]       req_cmd,
   input logic [LANES-1:0] req_mask,
   input logic             rsp_valid
);
   logic acc;
   assign acc = req_valid && req_ready;

   assert_full_write_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && FAST_FULL_WRITE && req_cmd == CMD_WRITE && (&req_mask)) |=> (req_ready && !rsp_valid));

   assert_partial_write_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_cmd == CMD_WRITE && !(&req_mask)) |=> (!req_ready && !rsp_valid));

   assert_read_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_cmd == CMD_READ) |=> rsp_valid);

   assert_atomic_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_cmd == CMD_ATOMIC) |=> rsp_valid);

   assert_modwr_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_cmd == CMD_MODWR) |=> !rsp_valid);

   assert_busy_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> req_ready);

   assert_single_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

bind mematom_unit mematom_chk #(.LANES(DATA_W/8), .FAST_FULL_WRITE(FAST_FULL_WRITE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_cmd   (req_cmd),
   .req_mask  (req_mask),
   .rsp_valid (rsp_valid)
);

// File: tb/sim_mematom_unit.sv
module sim_mematom_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_cmd = 2'd0;
   logic [3:0]  req_addr = 4'd0;
   logic [7:0]  req_mask = 8'd0;
   logic [2:0]  req_op = 3'd0;
   logic [63:0] req_data = 64'd0;
   logic        rsp_valid;
   logic [63:0] rsp_data;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;

   logic [63:0] model [16];
   logic [63:0] seed = 64'h0123_4567_89ab_cdef;

   logic        s_v1, s_r1, s_v2, s_r2;
   logic [63:0] s_d1;

   always #2 clk = ~clk;

   mematom_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_cmd(req_cmd), .req_addr(req_addr), .req_mask(req_mask), .req_op(req_op),
      .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] next_rand();
      seed = seed * 64'h5851_F42D_4C95_7F2D + 64'h1405_7B7E_F767_814F;
      return seed;
   endfunction

   function automatic logic [63:0] ref_op(input logic [2:0] o, input logic [63:0] w, input logic [63:0] d);
      case (o)
         3'd0: return w + d;
         3'd1: return w & d;
         3'd2: return w | d;
         3'd3: return w ^ d;
         3'd4: return d;
         default: return w;
      endcase
   endfunction

   function automatic logic [63:0] ref_merge(input logic [7:0] m, input logic [63:0] o, input logic [63:0] n);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[8*i +: 8] = m[i] ? n[8*i +: 8] : o[8*i +: 8];
      return r;
   endfunction

   task automatic txn(input logic [1:0] c, input logic [3:0] a, input logic [7:0] m,
                      input logic [2:0] o, input logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_cmd = c; req_addr = a; req_mask = m; req_op = o; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      s_v1 = rsp_valid; s_d1 = rsp_data; s_r1 = req_ready;
      @(negedge clk);
      s_v2 = rsp_valid; s_r2 = req_ready;
   endtask

   task automatic read_check(input logic [3:0] a, input string tag);
      txn(2'd0, a, 8'h00, 3'd0, 64'd0);
      check(s_v1, {tag, " R4 read beat"}, {63'd0, s_v1}, 64'd1);
      check(s_d1 == model[a], {tag, " stored word"}, s_d1, model[a]);
      check(!s_r1 && s_r2 && !s_v2, "R9 read busy one cycle, single beat", {62'd0, s_r1, s_v2}, 64'd0);
   endtask

   initial begin
      logic [7:0] pmask [6];
      logic [7:0] omask [4];
      logic [63:0] d, old;
      pmask = '{8'h00, 8'h01, 8'h80, 8'h0f, 8'ha5, 8'hfe};
      omask = '{8'hff, 8'h0f, 8'h5a, 8'h00};

      repeat (3) @(negedge clk);
      check(req_ready === 1'b1, "R1 ready after reset", {63'd0, req_ready}, 64'd1);
      check(rsp_valid === 1'b0, "R1 no reply after reset", {63'd0, rsp_valid}, 64'd0);
      rst_n = 1'b1;

      for (int a = 0; a < 16; a++) begin
         d = next_rand();
         txn(2'd1, a[3:0], 8'hff, 3'd0, d);
         model[a] = d;
         check(s_r1 && !s_v1 && !s_v2, "R2 full write single cycle, no reply",
               {62'd0, s_r1, s_v1 | s_v2}, 64'h2);
      end
      for (int a = 0; a < 16; a++) read_check(a[3:0], "R2");

      for (int k = 0; k < 6; k++) begin
         d = next_rand();
         txn(2'd1, k[3:0] + 4'd4, pmask[k], 3'd0, d);
         check(!s_r1 && s_r2 && !s_v1 && !s_v2, "R3 partial write timing, no reply",
               {60'd0, s_r1, s_r2, s_v1, s_v2}, 64'h4);
         model[k + 4] = ref_merge(pmask[k], model[k + 4], d);
         read_check(k[3:0] + 4'd4, "R3");
      end

      for (int o = 0; o < 8; o++) begin
         for (int mi = 0; mi < 4; mi++) begin
            for (int ci = 0; ci < 2; ci++) begin
               logic [3:0] a;
               a = 4'((o * 4 + mi + ci * 7) % 16);
               d = next_rand();
               old = model[a];
               txn(ci == 0 ? 2'd2 : 2'd3, a, omask[mi], o[2:0], d);
               model[a] = ref_merge(omask[mi], old, ref_op(o[2:0], old, d));
               if (ci == 0) begin
                  check(s_v1, "R5 atomic reply beat", {63'd0, s_v1}, 64'd1);
                  check(s_d1 == old, "R5 R7 atomic returns full old word", s_d1, old);
               end else begin
                  check(!s_v1 && !s_v2, "R8 modify-write has no reply", {62'd0, s_v1, s_v2}, 64'd0);
               end
               check(!s_r1 && s_r2, "R9 busy exactly one cycle", {62'd0, s_r1, s_r2}, 64'd1);
               read_check(a, "R6 R7");
            end
         end
      end

      txn(2'd1, 4'd3, 8'hff, 3'd0, 64'hffff_ffff_ffff_ffff);
      model[3] = 64'hffff_ffff_ffff_ffff;
      txn(2'd2, 4'd3, 8'hff, 3'd0, 64'd1);
      check(s_d1 == 64'hffff_ffff_ffff_ffff, "R5 old word before wrap", s_d1, 64'hffff_ffff_ffff_ffff);
      model[3] = 64'd0;
      read_check(4'd3, "R6 add wraps across all bytes");

      txn(2'd1, 4'd9, 8'hff, 3'd0, 64'h00ff_00ff_00ff_00ff);
      model[9] = 64'h00ff_00ff_00ff_00ff;
      txn(2'd3, 4'd9, 8'hff, 3'd0, 64'h0000_0000_0000_0001);
      model[9] = 64'h00ff_00ff_00ff_0100;
      read_check(4'd9, "R6 R8 carry crosses byte lane");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule